// File: doc/BRIEF.md
# Parallel NOR Flash Configuration Reader

This block is the master side of a byte-wide configuration load from a parallel NOR flash. It stays idle after reset until an init strobe rises. At that single instant it reads a 3-bit mode input. If the code selects the upward byte-wide read, the block takes the flash bus. It asserts chip-enable and output-enable and keeps write disabled. It parks the address at zero for a fixed number of configuration clock periods, then reads one byte per period while the address climbs by one. Every captured byte goes to downstream logic as a one-cycle valid pulse together with the data.

The configuration clock is made from the system clock by a divider whose half-period starts at a parameter value. Downstream logic that parses the stream can load a faster half-period partway through. The new value takes effect at the next rising edge, so no period is cut short. The read ends in one of three ways. A byte-count limit is reached, or an external done input arrives, and the block releases the bus and reports done. If the address reaches all ones first, the block releases the bus and reports an error instead.

Top module: `flash_cfg_reader`

## Requirements
- R1: After reset, done, error, busDrive, byteValid and cfgClk are 0, and flashCeN and flashOeN are 1.
- R2: The mode input is sampled only on the first rising edge of initStrobe after reset. Code 3'b010 starts a read. Any other code leaves the block idle with cfgClk low until reset, and later strobe edges are ignored. Once a read has started, changes on the mode input have no effect.
- R3: While busDrive is 1, flashCeN and flashOeN are 0 and flashWeN is 1. From the start of a read, flashAddr stays 0 through HOLD_CYC (default 5) rising edges of cfgClk. The first byte is captured on rising edge HOLD_CYC+1.
- R4: flashData is captured on the system clock edge at which cfgClk rises. byteValid is high in the first system cycle in which cfgClk is high, and byteData holds the captured value. While busDrive is 1, flashAddr changes only on an edge at which cfgClk falls.
- R5: Bytes are delivered in address order 0, 1, 2, and so on. flashAddr equals the byte's index while its byteValid is high, and each address step is +1.
- R6: cfgClk high and low phases each last INIT_HALF system cycles (default 4) at the start of every read. A rateLoad pulse with rateDiv of 1 or more during a read sets the half-period to rateDiv from the next rising edge of cfgClk. Both phases of every period are equal. rateDiv = 0 is ignored.
- R7: With byteLimit = N (N of 1 or more), the read stops after N bytes and done goes to 1. No more bytes follow, and flashAddr stays at N-1. byteLimit = 0 means no limit.
- R8: extDone high during a read sets done on the next clock edge, and no further byte is delivered.
- R9: When done or error is 1, busDrive is 0 and flashCeN and flashOeN are 1. From the next cycle on, cfgClk is 0.
- R10: If the byte at the all-ones address is captured without the limit being reached, error goes to 1, done stays 0 and reading stops. If that byte also meets the limit, done wins and error stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| initStrobe | input | 1 | Init strobe; its first rising edge samples the mode |
| modeIn | input | 3 | Mode code; 3'b010 selects the upward byte read |
| rateLoad | input | 1 | One-cycle pulse that loads a new half-period |
| rateDiv | input | DIV_W | New half-period in system cycles |
| byteLimit | input | ADDR_W+1 | Number of bytes to read; 0 means no limit |
| extDone | input | 1 | External request to end the read |
| flashData | input | 8 | Data bus from the flash |
| cfgClk | output | 1 | Divided configuration clock |
| flashAddr | output | ADDR_W | Flash byte address |
| flashCeN | output | 1 | Flash chip enable, active low |
| flashOeN | output | 1 | Flash output enable, active low |
| flashWeN | output | 1 | Flash write enable, active low, held inactive |
| busDrive | output | 1 | Output enable for address and control pins |
| byteValid | output | 1 | One-cycle pulse per captured byte |
| byteData | output | 8 | Captured byte |
| done | output | 1 | Read finished normally |
| error | output | 1 | Address space ran out before done |

## Verification
The hardest state to reach from the ports is the exhausted address space, because at the default width it takes 2^26 bytes. The bench builds the block with a 6-bit address. It then loads a half-period of one shortly after the first byte, so the whole space is read within a few hundred cycles. The run ends with the error flag set and exactly 64 bytes delivered. A second run sets the limit to exactly 64 so that the limit and the all-ones address meet on the same byte, which exercises the priority of done over error. The rate switch is checked by measuring every phase of cfgClk around a rejected zero load and an accepted load in the middle of the stream.

// File: rtl/flash_cfg_pkg.sv
package flash_cfg_pkg;

  // Mode code that selects the upward byte-wide read.
  localparam logic [2:0] MODE_BYTE_UP = 3'b010;

  // Strobes from control to datapath.
  typedef struct packed {
    logic clear;    // restart: address and byte count to zero
    logic capture;  // take flashData on this edge
    logic advance;  // step the address by one
  } dpStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,  // waiting for the first init edge
    ST_OFF,   // other mode sampled; stays here until reset
    ST_HOLD,  // address zero parked for the initial periods
    ST_READ,  // one byte per configuration clock period
    ST_DONE,  // finished normally, bus released
    ST_ERR    // address space ran out, bus released
  } cfgState_t;

endpackage

// File: rtl/cfg_clk_gen.sv
module cfg_clk_gen #(
  parameter int DIV_W     = 8,
  parameter int INIT_HALF = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic             rateLoad,
  input  logic [DIV_W-1:0] rateDiv,
  output logic             cfgClk,
  output logic             riseTick,
  output logic             fallTick
);

  localparam logic [DIV_W-1:0] INIT_HALF_V = DIV_W'(INIT_HALF);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] curHalf;
  logic [DIV_W-1:0] pendHalf;
  logic             pendValid;
  logic             loadOk;
  logic             term;

  assign loadOk   = run && rateLoad && (rateDiv != '0);
  assign term     = run && (cnt == curHalf - 1'b1);
  // The ticks mark the system edge on which cfgClk changes.
  assign riseTick = term && !cfgClk;
  assign fallTick = term && cfgClk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= '0;
      cfgClk    <= 1'b0;
      curHalf   <= INIT_HALF_V;
      pendHalf  <= INIT_HALF_V;
      pendValid <= 1'b0;
    end else if (!run) begin
      // Parked low, and every new read starts at the default rate.
      cnt       <= '0;
      cfgClk    <= 1'b0;
      curHalf   <= INIT_HALF_V;
      pendValid <= 1'b0;
    end else begin
      if (loadOk) begin
        pendHalf  <= rateDiv;
        pendValid <= 1'b1;
      end
      if (term) begin
        cnt    <= '0;
        cfgClk <= ~cfgClk;
        // A new rate is adopted only where a period begins.
        if (!cfgClk && pendValid) begin
          curHalf <= pendHalf;
          if (!loadOk) pendValid <= 1'b0;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/cfg_read_ctrl.sv
module cfg_read_ctrl
  import flash_cfg_pkg::*;
#(
  parameter int HOLD_CYC = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       initStrobe,
  input  logic [2:0] modeIn,
  input  logic       extDone,
  input  logic       riseTick,
  input  logic       fallTick,
  input  logic       addrMax,
  input  logic       lastByte,
  output dpStrobe_t  strb,
  output logic       run,
  output logic       done,
  output logic       error
);

  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYC);

  cfgState_t   state, stateNext;
  logic [HW-1:0] holdCnt, holdNext;
  logic        initPrev;
  logic        initRise;
  cfgState_t   afterCap;

  assign initRise = initStrobe && !initPrev;

  // The limit takes priority over running out of address space.
  always_comb begin
    if (lastByte)     afterCap = ST_DONE;
    else if (addrMax) afterCap = ST_ERR;
    else              afterCap = ST_READ;
  end

  always_comb begin
    stateNext = state;
    holdNext  = holdCnt;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        if (initRise) begin
          if (modeIn == MODE_BYTE_UP) begin
            stateNext  = ST_HOLD;
            strb.clear = 1'b1;
            holdNext   = '0;
          end else begin
            stateNext = ST_OFF;
          end
        end
      end
      ST_HOLD: begin
        if (extDone) begin
          stateNext = ST_DONE;
        end else if (riseTick) begin
          if (holdCnt == HOLD_LAST) begin
            strb.capture = 1'b1;
            stateNext    = afterCap;
          end else begin
            holdNext = holdCnt + 1'b1;
          end
        end
      end
      ST_READ: begin
        if (extDone) begin
          stateNext = ST_DONE;
        end else if (riseTick) begin
          strb.capture = 1'b1;
          stateNext    = afterCap;
        end else if (fallTick) begin
          strb.advance = 1'b1;
        end
      end
      default: begin
        stateNext = state;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      holdCnt  <= '0;
      initPrev <= 1'b0;
    end else begin
      state    <= stateNext;
      holdCnt  <= holdNext;
      initPrev <= initStrobe;
    end
  end

  assign run   = (state == ST_HOLD) || (state == ST_READ);
  assign done  = (state == ST_DONE);
  assign error = (state == ST_ERR);

endmodule

// File: rtl/cfg_read_dp.sv
module cfg_read_dp
  import flash_cfg_pkg::*;
#(
  parameter int ADDR_W = 26
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [7:0]        flashData,
  input  logic [ADDR_W:0]   byteLimit,
  output logic [ADDR_W-1:0] addr,
  output logic [7:0]        byteData,
  output logic              byteValid,
  output logic              addrMax,
  output logic              lastByte
);

  logic [ADDR_W:0] byteCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr      <= '0;
      byteCnt   <= '0;
      byteData  <= '0;
      byteValid <= 1'b0;
    end else begin
      byteValid <= strb.capture;
      if (strb.clear) begin
        addr    <= '0;
        byteCnt <= '0;
      end else begin
        if (strb.capture) begin
          byteData <= flashData;
          byteCnt  <= byteCnt + 1'b1;
        end
        if (strb.advance) addr <= addr + 1'b1;
      end
    end
  end

  assign addrMax  = &addr;
  assign lastByte = (byteLimit != '0) && ((byteCnt + 1'b1) == byteLimit);

endmodule

// File: rtl/flash_cfg_reader.sv
module flash_cfg_reader
  import flash_cfg_pkg::*;
#(
  parameter int ADDR_W    = 26,
  parameter int DIV_W     = 8,
  parameter int INIT_HALF = 4,
  parameter int HOLD_CYC  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              initStrobe,
  input  logic [2:0]        modeIn,
  input  logic              rateLoad,
  input  logic [DIV_W-1:0]  rateDiv,
  input  logic [ADDR_W:0]   byteLimit,
  input  logic              extDone,
  input  logic [7:0]        flashData,
  output logic              cfgClk,
  output logic [ADDR_W-1:0] flashAddr,
  output logic              flashCeN,
  output logic              flashOeN,
  output logic              flashWeN,
  output logic              busDrive,
  output logic              byteValid,
  output logic [7:0]        byteData,
  output logic              done,
  output logic              error
);

  dpStrobe_t strb;
  logic      run;
  logic      riseTick;
  logic      fallTick;
  logic      addrMax;
  logic      lastByte;

  cfg_clk_gen #(
    .DIV_W    (DIV_W),
    .INIT_HALF(INIT_HALF)
  ) clkGen (
    .clk     (clk),
    .rstN    (rstN),
    .run     (run),
    .rateLoad(rateLoad),
    .rateDiv (rateDiv),
    .cfgClk  (cfgClk),
    .riseTick(riseTick),
    .fallTick(fallTick)
  );

  cfg_read_ctrl #(
    .HOLD_CYC(HOLD_CYC)
  ) ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .initStrobe(initStrobe),
    .modeIn    (modeIn),
    .extDone   (extDone),
    .riseTick  (riseTick),
    .fallTick  (fallTick),
    .addrMax   (addrMax),
    .lastByte  (lastByte),
    .strb      (strb),
    .run       (run),
    .done      (done),
    .error     (error)
  );

  cfg_read_dp #(
    .ADDR_W(ADDR_W)
  ) dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .flashData(flashData),
    .byteLimit(byteLimit),
    .addr     (flashAddr),
    .byteData (byteData),
    .byteValid(byteValid),
    .addrMax  (addrMax),
    .lastByte (lastByte)
  );

  assign busDrive = run;
  assign flashCeN = ~run;
  assign flashOeN = ~run;
  // Writes are never issued; the pin reads inactive whether driven or released.
  assign flashWeN = 1'b1;

endmodule

// File: rtl/flash_cfg_reader_chk.sv
module flash_cfg_reader_chk #(
  parameter int ADDR_W = 26
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgClk,
  input logic [ADDR_W-1:0] flashAddr,
  input logic              flashCeN,
  input logic              flashOeN,
  input logic              flashWeN,
  input logic              busDrive,
  input logic              byteValid,
  input logic              done,
  input logic              error
);

  // R3
  drive_ctl_chk: assert property (@(posedge clk) disable iff (!rstN)
    busDrive |-> (!flashCeN && !flashOeN && flashWeN));

  // R9
  release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done || error) |-> (!busDrive && flashCeN && flashOeN));

  // R9
  clk_park_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done || error) |=> !cfgClk);

  // R4
  capture_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> $rose(cfgClk));

  // R4
  addr_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busDrive && $past(busDrive) && (flashAddr != $past(flashAddr))) |-> $fell(cfgClk));

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busDrive && $past(busDrive) && (flashAddr != $past(flashAddr)))
      |-> (flashAddr == ADDR_W'($past(flashAddr) + 1'b1)));

  // R10
  err_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    error |-> !done);

  // R7
  stop_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !byteValid);

  // R10
  stop_after_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    error |=> !byteValid);

endmodule

bind flash_cfg_reader flash_cfg_reader_chk #(.ADDR_W(ADDR_W)) chkInst (
  .clk      (clk),
  .rstN     (rstN),
  .cfgClk   (cfgClk),
  .flashAddr(flashAddr),
  .flashCeN (flashCeN),
  .flashOeN (flashOeN),
  .flashWeN (flashWeN),
  .busDrive (busDrive),
  .byteValid(byteValid),
  .done     (done),
  .error    (error)
);

// File: tb/tb_flash_cfg_reader.sv
module tb_flash_cfg_reader;

  localparam int AW = 6;
  localparam int DW = 8;
  localparam int IH = 4;
  localparam int HC = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          initStrobe = 1'b0;
  logic [2:0]    modeIn = 3'b000;
  logic          rateLoad = 1'b0;
  logic [DW-1:0] rateDiv = '0;
  logic [AW:0]   byteLimit = '0;
  logic          extDone = 1'b0;
  logic [7:0]    flashData;
  logic          cfgClk;
  logic [AW-1:0] flashAddr;
  logic          flashCeN, flashOeN, flashWeN, busDrive, byteValid, done, error;
  logic [7:0]    byteData;

  always #2 clk = ~clk;

  flash_cfg_reader #(
    .ADDR_W(AW), .DIV_W(DW), .INIT_HALF(IH), .HOLD_CYC(HC)
  ) dut (
    .clk(clk), .rstN(rstN), .initStrobe(initStrobe), .modeIn(modeIn),
    .rateLoad(rateLoad), .rateDiv(rateDiv), .byteLimit(byteLimit),
    .extDone(extDone), .flashData(flashData), .cfgClk(cfgClk),
    .flashAddr(flashAddr), .flashCeN(flashCeN), .flashOeN(flashOeN),
    .flashWeN(flashWeN), .busDrive(busDrive), .byteValid(byteValid),
    .byteData(byteData), .done(done), .error(error)
  );

  // Flash model: byte content computed from the address.
  function automatic logic [7:0] memByte(input int a);
    return 8'((a * 37 + 11) ^ (a >> 2));
  endfunction

  assign flashData = memByte(int'(flashAddr));

  int nChecks = 0;
  int nErr = 0;
  int expData[$];
  int expAddr[$];
  int bytesSeen = 0;
  int riseCnt = 0;
  int riseTotal = 0;
  int holdRises = 0;
  int holdViol = 0;
  int phaseViol = 0;
  int edgeViol = 0;
  int curLen = 0;
  int hiLen = 0;
  int measuredHalf = 0;
  bit haveHi = 1'b0;
  bit firstSeen = 1'b0;
  logic prevCfg = 1'b0;
  logic prevBus = 1'b0;
  logic [AW-1:0] prevAddr = '0;
  string curReq = "R7";

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor and scoreboard, sampled away from the active edge.
  always @(negedge clk) begin
    bit rose, fell;
    int d, a;
    if (rstN) begin
      if (busDrive && !prevBus) begin
        riseCnt = 0; firstSeen = 1'b0; holdViol = 0; haveHi = 1'b0; curLen = 0;
      end
      rose = cfgClk && !prevCfg;
      fell = !cfgClk && prevCfg;
      if (rose) riseTotal++;
      // R4: address moves only with a falling cfgClk, bytes only with a rising one
      if (busDrive && prevBus && (flashAddr != prevAddr) && !fell) edgeViol++;
      if (byteValid && !rose) edgeViol++;
      if (rose && !firstSeen) riseCnt++;
      // R3: parked address and asserted controls during the hold
      if (busDrive && !firstSeen &&
          ((flashAddr != '0) || flashCeN || flashOeN || !flashWeN)) holdViol++;
      // R6: phase lengths
      if (rose || fell) begin
        if (fell) begin
          hiLen = curLen; haveHi = 1'b1;
        end else if (haveHi) begin
          if (curLen != hiLen) phaseViol++;
          measuredHalf = curLen;
        end
        curLen = 1;
      end else begin
        curLen++;
      end
      if (byteValid) begin
        if (!firstSeen) begin
          firstSeen = 1'b1; holdRises = riseCnt;
        end
        if (expData.size() == 0) begin
          check(1'b0, curReq, "unexpected byte", bytesSeen, -1);
        end else begin
          d = expData.pop_front();
          a = expAddr.pop_front();
          check(byteData == 8'(d), "R5", "byte value", byteData, d);
          check(int'(flashAddr) == a, "R5", "address at capture", flashAddr, a);
        end
        bytesSeen++;
      end
    end
    prevCfg  = cfgClk;
    prevBus  = busDrive;
    prevAddr = flashAddr;
  end

  // Driver side: expected items go into the queue before the read starts.
  task automatic pushExpected(input int n);
    for (int i = 0; i < n; i++) begin
      expData.push_back(int'(memByte(i)));
      expAddr.push_back(i);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    initStrobe = 1'b0; rateLoad = 1'b0; extDone = 1'b0;
    repeat (3) @(negedge clk);
    expData.delete(); expAddr.delete();
    bytesSeen = 0; riseTotal = 0; edgeViol = 0; phaseViol = 0; measuredHalf = 0;
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic startRun(input int limit, input int nExp);
    byteLimit = (AW+1)'(limit);
    pushExpected(nExp);
    modeIn = 3'b010;
    @(negedge clk);
    initStrobe = 1'b1;
    @(negedge clk);
    modeIn = 3'b000;  // R2: later mode changes must not matter
    @(negedge clk);
    initStrobe = 1'b0;
  endtask

  task automatic loadRate(input int h);
    rateDiv = DW'(h);
    rateLoad = 1'b1;
    @(negedge clk);
    rateLoad = 1'b0;
  endtask

  task automatic waitBytes(input int n);
    while (bytesSeen < n) @(negedge clk);
  endtask

  task automatic waitEnd();
    while (!(done || error)) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nErr++;
    $display("FAIL watchdog (all): actual=timeout expected=finished");
    $display("  Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    int b;
    doReset();
    // R1: reset state
    check(!done && !error, "R1", "done/error after reset", {done, error}, 0);
    check(!busDrive && !byteValid && !cfgClk, "R1", "bus/valid/clock after reset",
          {busDrive, byteValid, cfgClk}, 0);
    check(flashCeN && flashOeN, "R1", "controls after reset", {flashCeN, flashOeN}, 3);

    // R2: another mode code stays idle; later edges are ignored
    curReq = "R2";
    modeIn = 3'b011;
    @(negedge clk); initStrobe = 1'b1;
    @(negedge clk); initStrobe = 1'b0;
    repeat (60) @(negedge clk);
    check(!busDrive && riseTotal == 0, "R2", "idle after other code (rises)", riseTotal, 0);
    modeIn = 3'b010;
    @(negedge clk); initStrobe = 1'b1;
    @(negedge clk); initStrobe = 1'b0;
    repeat (60) @(negedge clk);
    check(!busDrive, "R2", "second init edge ignored (busDrive)", busDrive, 0);
    check(riseTotal == 0, "R2", "second init edge ignored (rises)", riseTotal, 0);

    // Main run: 20 bytes, zero rate rejected, then switch to half-period 2
    doReset();
    curReq = "R7";
    startRun(20, 20);
    repeat (3) @(negedge clk);
    check(busDrive == 1'b1, "R2", "read runs after mode change", busDrive, 1);
    waitBytes(3);
    loadRate(0);
    waitBytes(7);
    check(measuredHalf == IH, "R6", "half-period after zero load", measuredHalf, IH);
    check(holdRises == HC + 1, "R3", "rising edges up to first capture", holdRises, HC + 1);
    check(holdViol == 0, "R3", "hold-phase violations", holdViol, 0);
    waitBytes(8);
    loadRate(2);
    waitEnd();
    check(done && !error, "R7", "done after limit", {done, error}, 2);
    check(bytesSeen == 20, "R7", "bytes delivered", bytesSeen, 20);
    check(expData.size() == 0, "R5", "bytes left in queue", expData.size(), 0);
    check(int'(flashAddr) == 19, "R7", "address at done", flashAddr, 19);
    check(!busDrive && flashCeN && flashOeN, "R9", "bus released at done",
          {busDrive, flashCeN, flashOeN}, 3);
    check(!cfgClk, "R9", "clock parked", cfgClk, 0);
    check(measuredHalf == 2, "R6", "half-period after load", measuredHalf, 2);
    check(phaseViol == 0, "R6", "unequal phases", phaseViol, 0);
    check(edgeViol == 0, "R4", "edge placement violations", edgeViol, 0);
    repeat (40) @(negedge clk);
    check(bytesSeen == 20 && int'(flashAddr) == 19, "R7", "quiet after done", bytesSeen, 20);

    // External done in the middle of the stream
    doReset();
    curReq = "R8";
    startRun(0, 30);
    waitBytes(5);
    extDone = 1'b1;
    @(negedge clk);
    extDone = 1'b0;
    check(done == 1'b1, "R8", "done one edge after request", done, 1);
    check(!busDrive, "R9", "bus released after request", busDrive, 0);
    b = bytesSeen;
    repeat (40) @(negedge clk);
    check(bytesSeen == b, "R8", "no byte after request", bytesSeen, b);
    check(!error, "R8", "no error on request", error, 0);
    expData.delete(); expAddr.delete();

    // Address space exhausted without a limit
    doReset();
    curReq = "R10";
    startRun(0, 64);
    waitBytes(1);
    loadRate(1);
    waitEnd();
    check(error && !done, "R10", "error flag after last address", {error, done}, 2);
    check(bytesSeen == 64, "R10", "bytes before error", bytesSeen, 64);
    check(!busDrive && flashCeN, "R9", "bus released on error", busDrive, 0);
    check(edgeViol == 0 && phaseViol == 0, "R4", "edges at fast rate", edgeViol + phaseViol, 0);
    repeat (40) @(negedge clk);
    check(bytesSeen == 64, "R10", "quiet after error", bytesSeen, 64);

    // Limit and last address on the same byte: done wins
    doReset();
    curReq = "R10";
    startRun(64, 64);
    waitBytes(1);
    loadRate(1);
    waitEnd();
    check(done && !error, "R10", "limit beats address exhaustion", {done, error}, 2);
    check(bytesSeen == 64, "R7", "bytes at exact limit", bytesSeen, 64);

    $display("  Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule